// File: doc/BRIEF.md
# Partitioned Byte-by-Scalar Multiplier

This block multiplies each of four unsigned byte lanes of a 32-bit operand by one shared signed 16-bit scalar. It returns a 64-bit word that holds four 16-bit lanes. Each output lane holds the middle 16 bits of its product. Before those bits are kept, the product is rounded on the byte that is dropped: when that low byte is above 0x7F, one unit is added at bit 8. The scalar is one halfword of a second 32-bit operand, and a select input chooses which halfword.

The unit has a single register stage. A sample presented with `in_valid` appears on `result` one clock later, flagged by `out_valid`. There is no back-pressure. The lane count, byte width and scalar width are parameters, and all other widths are derived from them.

Top module: `pmul_byte_scalar`

## Requirements
- R1: Byte lanes are unsigned and keep their order. The byte in `src_a[31:24]` produces `result[63:48]`, and each following byte produces the next lower 16-bit lane.
- R2: The scalar is read as signed. It is `src_b[31:16]` when `op_hi` is 1 and `src_b[15:0]` when `op_hi` is 0.
- R3: Each lane product is the exact value of byte times scalar. When the product's low 8 bits exceed 0x7F, 0x100 is added to it before truncation.
- R4: Each result lane is bits [23:8] of the rounded product. It wraps to 16 bits and never saturates, so 0xFF times 0x8000 gives 0x8080.
- R5: Every result lane is computed fresh from the current operands, with nothing carried over from earlier results. A zero byte, or a zero scalar, gives a zero lane.
- R6: `out_valid` equals `in_valid` delayed by exactly one clock.
- R7: `result` loads only on a clock where `in_valid` is 1, and holds its value on every other clock.
- R8: A synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_hi | input | 1 | 1 selects the upper halfword of `src_b` as scalar, 0 selects the lower |
| src_a | input | 32 | Four unsigned byte lanes, lane 0 in the top byte |
| src_b | input | 32 | Holds the two candidate signed scalars |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 64 | Four 16-bit rounded products, lane 0 in the top halfword |

## Verification
The bench builds the unit with its default parameters: four lanes of 8 bits and a 16-bit scalar. That matches the width of the rounding point and the lane packing fixed by the requirements. With these values, the hand-computed vectors reach both extremes of the scalar against a full byte, the rounding threshold at exactly 0x7F and 0x80, and the selection of either halfword from the same operands. A behavioural reference model written with integer arithmetic covers a further sweep of operand patterns.

// File: rtl/pmul_byte_scalar.sv
module pmul_byte_scalar #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  parameter int SW    = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  op_hi,
  input  logic [LANES*BW-1:0]   src_a,
  input  logic [2*SW-1:0]       src_b,
  output logic                  out_valid,
  output logic [LANES*SW-1:0]   result
);
  localparam int PW   = BW + SW;
  localparam int RW   = LANES * SW;
  localparam int HALF = (1 << (BW - 1)) - 1;

  logic [SW-1:0] scalar;
  logic [RW-1:0] lanes_d;

  assign scalar = op_hi ? src_b[2*SW-1:SW] : src_b[SW-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [PW-1:0] a_ext, s_ext, prod;
    logic                 bump;
    assign a_ext = {{SW{1'b0}}, src_a[g*BW +: BW]};
    assign s_ext = {{BW{scalar[SW-1]}}, scalar};
    assign prod  = a_ext * s_ext;
    assign bump  = (prod[BW-1:0] > BW'(HALF));
    assign lanes_d[g*SW +: SW] = prod[PW-1:BW] + SW'(bump);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= lanes_d;
    end
  end
endmodule

// File: rtl/pmul_byte_scalar_chk.sv
module pmul_byte_scalar_chk #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  parameter int SW    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                op_hi,
  input logic [LANES*BW-1:0] src_a,
  input logic [2*SW-1:0]     src_b,
  input logic                out_valid,
  input logic [LANES*SW-1:0] result
);
  assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));
  assert_zero_scalar_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_hi ? src_b[2*SW-1:SW] : src_b[SW-1:0]) == '0) |=> result == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_zb
    assert_zero_byte_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && src_a[g*BW +: BW] == '0) |=> result[g*SW +: SW] == '0);
  end
endmodule

bind pmul_byte_scalar pmul_byte_scalar_chk #(.LANES(LANES), .BW(BW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_hi(op_hi),
  .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result));

// File: tb/test_pmul_byte_scalar.sv
module test_pmul_byte_scalar;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_hi = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pmul_byte_scalar i_pmul_byte_scalar (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_hi(op_hi),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result));

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        hi;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'hFF000180, 32'h80000001, 1'b1, 64'h8080_0000_FF80_C000},
    '{32'hFF000180, 32'h80000001, 1'b0, 64'h0001_0000_0000_0001},
    '{32'h010102FF, 32'h0080007F, 1'b0, 64'h0000_0000_0001_007F},
    '{32'h010102FF, 32'h0080007F, 1'b1, 64'h0001_0001_0001_0080},
    '{32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1, 64'h7F7F_7F7F_7F7F_7F7F},
    '{32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  function automatic logic [63:0] ref_word(logic [31:0] a, logic [31:0] b, logic hi);
    logic signed [15:0] s;
    logic [63:0] w;
    s = hi ? b[31:16] : b[15:0];
    for (int i = 0; i < 4; i++) begin
      int p;
      p = int'(a[31-8*i -: 8]) * int'(s);
      if ((p & 255) > 127) p = p + 256;
      w[63-16*i -: 16] = 16'(p >>> 8);
    end
    return w;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, logic hi);
    @(negedge clk);
    src_a = a; src_b = b; op_hi = hi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", 64'(out_valid), 64'd0);
    check("R8 reset result", result, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].hi);
      check("R6 valid", 64'(out_valid), 64'd1);
      check("R1 R2 R3 R4 table", result, VECS[i].exp);
      check("R3 model agrees with table", ref_word(VECS[i].a, VECS[i].b, VECS[i].hi), VECS[i].exp);
    end

    begin
      logic [31:0] a, b;
      a = 32'h13579BDF; b = 32'hACE1F00D;
      for (int i = 0; i < 12; i++) begin
        apply(a, b, i[0]);
        check("R1 R2 R3 R4 sweep", result, ref_word(a, b, i[0]));
        a = {a[26:0], a[31:27]} ^ 32'h9E3779B9;
        b = {b[18:0], b[31:19]} + 32'h7F4A7C15;
      end
    end

    apply(32'h00FF0000, 32'h8000_7FFF, 1'b1);
    check("R5 zero bytes", result, 64'h0000_8080_0000_0000);
    apply(32'hFFFFFFFF, 32'h0000_1234, 1'b0);
    check("R2 upper ignored", result, ref_word(32'hFFFFFFFF, 32'h0000_1234, 1'b0));
    apply(32'hFFFFFFFF, 32'h0000_1234, 1'b1);
    check("R5 zero scalar", result, 64'd0);

    apply(32'h010102FF, 32'h0080007F, 1'b1);
    @(negedge clk);
    src_a = 32'hFFFFFFFF; src_b = 32'h7FFF7FFF; op_hi = 1'b0;
    @(negedge clk);
    check("R6 idle valid", 64'(out_valid), 64'd0);
    check("R7 hold", result, 64'h0001_0001_0001_0080);

    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R8 mid reset valid", 64'(out_valid), 64'd0);
    check("R8 mid reset result", result, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule